// File: doc/BRIEF.md
# Deterministic XY Mesh Router Tile

This block is one tile of a two-dimensional mesh network-on-chip. Each tile has five flit ports: one toward the attached core and scratchpad, and one toward each of the four neighbouring tiles. Every flit carries the column and row of the tile it is bound for. The router works out a fixed path for each flit and forwards it through one output register per hop. A flit that has reached its own tile leaves through the core-facing port.

The path is set by the destination alone. A flit first moves along the row until its column matches, and only then along the column. Because the path is static and every hop is one register stage, a flit that meets no contention reaches its target after a fixed number of cycles: one per tile it passes through.

Every port uses a valid/ready handshake. When several inputs want the same output in one cycle, a round-robin arbiter for that output picks one winner. The other inputs see ready low and hold their flits. An output whose register is full and whose downstream ready is low accepts nothing.

Top module: `mesh_router`

## Requirements
- R1: Port bundle index 0 is local, 1 is north (increasing row), 2 is south, 3 is east (increasing column) and 4 is west. Every output valid is low while reset is held and in the first cycle after it.
- R2: A flit is laid out as {dst_x, dst_y, payload}, with dst_x in the top COORD_W bits. A flit whose dst_x differs from the tile's column leaves east when dst_x is larger and west when it is smaller, whatever its dst_y.
- R3: A flit whose dst_x equals the tile's column but whose dst_y differs leaves north when dst_y is larger and south when it is smaller.
- R4: A flit whose dst_x and dst_y both equal the tile's own coordinate leaves through the local port.
- R5: While an output is valid and its ready is low, that output keeps its flit unchanged, and no input bound for it is accepted.
- R6: Each output takes at most one input per cycle. An input is accepted only while its valid is high.
- R7: While several inputs keep requesting one output that is free every cycle, the grants rotate. No input wins twice in a row, and each of k contenders wins once in every k grants.
- R8: A flit accepted at a clock edge appears, unchanged, on its output port right after that same edge. Each hop therefore adds exactly one cycle.
- R9: Inputs bound for distinct free outputs are all accepted in the same cycle.
- R10: In a mesh of these tiles with no contention, a flit injected at a local port appears at the destination's local output D+1 clock edges after injection, where D is the Manhattan distance between the two tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit valid, indexed as in R1 |
| in_flit | input | 5*(2*COORD_W+PAYLOAD_W) | Per-input flit; slice i holds input i |
| in_ready | output | 5 | Per-input accept, high when the flit is taken this cycle |
| out_valid | output | 5 | Per-output register holds a flit |
| out_flit | output | 5*(2*COORD_W+PAYLOAD_W) | Per-output registered flit |
| out_ready | input | 5 | Downstream can take the output flit |

## Verification
Each kind of internal fault shows up at the ports within one clock edge of the flit that triggers it:
- A wrong route decode puts the flit on the wrong output right after the accepting edge.
- A broken output register either drops or repeats a flit on the next cycle, or lets a stalled flit change while ready is low.
- A stuck or mis-stepped round-robin pointer shows as the same contender seeing ready twice in a row, or as uneven win counts over a few contended cycles.
- Across a small mesh, any extra or missing register stage shows as a delivery cycle that differs from the hop count plus one.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
    localparam int NPORTS  = 5;
    localparam int P_LOCAL = 0;
    localparam int P_NORTH = 1;
    localparam int P_SOUTH = 2;
    localparam int P_EAST  = 3;
    localparam int P_WEST  = 4;

    typedef logic [NPORTS-1:0] port_vec_t;
endpackage

// File: rtl/mesh_route_calc.sv
module mesh_route_calc
    import mesh_router_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 0,
    parameter int MY_Y    = 0
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output port_vec_t          dir
);
    localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

    // Column first, then row, then eject.
    always_comb begin
        dir = '0;
        if (dst_x > OWN_X)      dir[P_EAST]  = 1'b1;
        else if (dst_x < OWN_X) dir[P_WEST]  = 1'b1;
        else if (dst_y > OWN_Y) dir[P_NORTH] = 1'b1;
        else if (dst_y < OWN_Y) dir[P_SOUTH] = 1'b1;
        else                    dir[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/mesh_rr_arb.sv
module mesh_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t       st_q, st_d;
    logic             found;
    logic [IDX_W-1:0] winner;
    int               idx;

    always_comb begin
        st_d   = st_q;
        grant  = '0;
        found  = 1'b0;
        winner = '0;
        idx    = 0;
        for (int k = 0; k < N; k++) begin
            idx = int'(st_q.ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
                winner     = IDX_W'(idx);
            end
        end
        if (advance && found)
            st_d.ptr = (winner == IDX_W'(N-1)) ? '0 : winner + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a single winner, and only among requesters
    p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    // R7: an unchanged set of several requesters never sees the same winner twice running
    p_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && $countones(req) > 1) |=> ((req != $past(req)) || (grant != $past(grant))));
endmodule

// File: rtl/mesh_out_slot.sv
module mesh_out_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         free
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_state_t;

    slot_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = din;
        end else if (ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign dout  = st_q.data;
    assign free  = !st_q.valid || ready;

    // R1: reset empties the register
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !valid);
    // R5: a stalled flit stays put and nothing overwrites it
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(dout)));
    p_load_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!valid || ready));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int COORD_W   = 4,
    parameter int PAYLOAD_W = 32,
    parameter int MY_X      = 0,
    parameter int MY_Y      = 0
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [NPORTS-1:0]                          in_valid,
    input  logic [NPORTS*(2*COORD_W+PAYLOAD_W)-1:0]    in_flit,
    output logic [NPORTS-1:0]                          in_ready,
    output logic [NPORTS-1:0]                          out_valid,
    output logic [NPORTS*(2*COORD_W+PAYLOAD_W)-1:0]    out_flit,
    input  logic [NPORTS-1:0]                          out_ready
);
    localparam int FLIT_W = 2*COORD_W + PAYLOAD_W;
    localparam int X_LSB  = COORD_W + PAYLOAD_W;
    localparam int Y_LSB  = PAYLOAD_W;
    localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

    logic [NPORTS-1:0][NPORTS-1:0] dir;      // dir[input][output]
    logic [NPORTS-1:0][NPORTS-1:0] req_out;  // req_out[output][input]
    logic [NPORTS-1:0][NPORTS-1:0] grant;    // raw arbiter choice
    logic [NPORTS-1:0][NPORTS-1:0] win;      // choice gated by a free slot
    logic [NPORTS-1:0]             slot_free;

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_in
        mesh_route_calc #(
            .COORD_W (COORD_W),
            .MY_X    (MY_X),
            .MY_Y    (MY_Y)
        ) u_route (
            .dst_x (in_flit[gi*FLIT_W + X_LSB +: COORD_W]),
            .dst_y (in_flit[gi*FLIT_W + Y_LSB +: COORD_W]),
            .dir   (dir[gi])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                req_out[o][i] = in_valid[i] && dir[i][o];
    end

    for (genvar go = 0; go < NPORTS; go++) begin : g_out
        logic [FLIT_W-1:0] sel_flit;

        mesh_rr_arb #(.N(NPORTS)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_out[go]),
            .advance (slot_free[go]),
            .grant   (grant[go])
        );

        assign win[go] = slot_free[go] ? grant[go] : '0;

        always_comb begin
            sel_flit = '0;
            for (int i = 0; i < NPORTS; i++)
                if (win[go][i]) sel_flit = sel_flit | in_flit[i*FLIT_W +: FLIT_W];
        end

        mesh_out_slot #(.W(FLIT_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (|win[go]),
            .din   (sel_flit),
            .ready (out_ready[go]),
            .valid (out_valid[go]),
            .dout  (out_flit[go*FLIT_W +: FLIT_W]),
            .free  (slot_free[go])
        );

        // R8: a flit taken at an edge sits in its output register right after it
        for (genvar gi = 0; gi < NPORTS; gi++) begin : g_fwd
            p_one_cycle_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid[gi] && in_ready[gi] && dir[gi][go]) |=>
                (out_valid[go] && out_flit[go*FLIT_W +: FLIT_W] == $past(in_flit[gi*FLIT_W +: FLIT_W])));
        end
    end

    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            in_ready[i] = 1'b0;
            for (int o = 0; o < NPORTS; o++)
                in_ready[i] = in_ready[i] | win[o][i];
        end
    end

    // R6: nothing is accepted without valid
    p_ready_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0);
    // R2: row-direction outputs only carry flits for other columns
    p_east_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_EAST] |-> (out_flit[P_EAST*FLIT_W + X_LSB +: COORD_W] > OWN_X));
    p_west_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_WEST] |-> (out_flit[P_WEST*FLIT_W + X_LSB +: COORD_W] < OWN_X));
    // R3: column-direction outputs only carry flits already in this column
    p_north_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_NORTH] |-> (out_flit[P_NORTH*FLIT_W + X_LSB +: COORD_W] == OWN_X &&
                                out_flit[P_NORTH*FLIT_W + Y_LSB +: COORD_W] > OWN_Y));
    p_south_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_SOUTH] |-> (out_flit[P_SOUTH*FLIT_W + X_LSB +: COORD_W] == OWN_X &&
                                out_flit[P_SOUTH*FLIT_W + Y_LSB +: COORD_W] < OWN_Y));
    // R4: the local port only ejects flits addressed to this tile
    p_local_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_LOCAL] |-> (out_flit[P_LOCAL*FLIT_W + X_LSB +: COORD_W] == OWN_X &&
                                out_flit[P_LOCAL*FLIT_W + Y_LSB +: COORD_W] == OWN_Y));
endmodule

// File: tb/mesh_router_test.sv
`timescale 1ns/1ps
module mesh_router_test;
    localparam int CW = 2;
    localparam int PW = 8;
    localparam int FW = 2*CW + PW;
    localparam int NP = 5;
    localparam int MS = 3;
    localparam int NN = MS*MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // single router at (1,1)
    logic [NP-1:0]    u_iv = '0;
    logic [NP*FW-1:0] u_ifl = '0;
    logic [NP-1:0]    u_ir;
    logic [NP-1:0]    u_ov;
    logic [NP*FW-1:0] u_ofl;
    logic [NP-1:0]    u_or = '1;

    mesh_router #(.COORD_W(CW), .PAYLOAD_W(PW), .MY_X(1), .MY_Y(1)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(u_iv), .in_flit(u_ifl), .in_ready(u_ir),
        .out_valid(u_ov), .out_flit(u_ofl), .out_ready(u_or)
    );

    // 3x3 mesh
    wire  [NN*NP-1:0]    m_iv, m_ir, m_ov, m_or;
    wire  [NN*NP*FW-1:0] m_ifl, m_ofl;
    logic [NN-1:0]       inj_v = '0;
    logic [NN*FW-1:0]    inj_f = '0;

    for (genvar gy = 0; gy < MS; gy++) begin : g_row
        for (genvar gx = 0; gx < MS; gx++) begin : g_col
            localparam int R = gy*MS + gx;
            assign m_iv[R*NP+0] = inj_v[R];
            assign m_ifl[(R*NP+0)*FW +: FW] = inj_f[R*FW +: FW];
            assign m_or[R*NP+0] = 1'b1;
            if (gy < MS-1) begin : g_n
                assign m_iv[R*NP+1] = m_ov[(R+MS)*NP+2];
                assign m_ifl[(R*NP+1)*FW +: FW] = m_ofl[((R+MS)*NP+2)*FW +: FW];
                assign m_or[R*NP+1] = m_ir[(R+MS)*NP+2];
            end else begin : g_nt
                assign m_iv[R*NP+1] = 1'b0;
                assign m_ifl[(R*NP+1)*FW +: FW] = '0;
                assign m_or[R*NP+1] = 1'b1;
            end
            if (gy > 0) begin : g_s
                assign m_iv[R*NP+2] = m_ov[(R-MS)*NP+1];
                assign m_ifl[(R*NP+2)*FW +: FW] = m_ofl[((R-MS)*NP+1)*FW +: FW];
                assign m_or[R*NP+2] = m_ir[(R-MS)*NP+1];
            end else begin : g_st
                assign m_iv[R*NP+2] = 1'b0;
                assign m_ifl[(R*NP+2)*FW +: FW] = '0;
                assign m_or[R*NP+2] = 1'b1;
            end
            if (gx < MS-1) begin : g_e
                assign m_iv[R*NP+3] = m_ov[(R+1)*NP+4];
                assign m_ifl[(R*NP+3)*FW +: FW] = m_ofl[((R+1)*NP+4)*FW +: FW];
                assign m_or[R*NP+3] = m_ir[(R+1)*NP+4];
            end else begin : g_et
                assign m_iv[R*NP+3] = 1'b0;
                assign m_ifl[(R*NP+3)*FW +: FW] = '0;
                assign m_or[R*NP+3] = 1'b1;
            end
            if (gx > 0) begin : g_w
                assign m_iv[R*NP+4] = m_ov[(R-1)*NP+3];
                assign m_ifl[(R*NP+4)*FW +: FW] = m_ofl[((R-1)*NP+3)*FW +: FW];
                assign m_or[R*NP+4] = m_ir[(R-1)*NP+3];
            end else begin : g_wt
                assign m_iv[R*NP+4] = 1'b0;
                assign m_ifl[(R*NP+4)*FW +: FW] = '0;
                assign m_or[R*NP+4] = 1'b1;
            end
            mesh_router #(.COORD_W(CW), .PAYLOAD_W(PW), .MY_X(gx), .MY_Y(gy)) node (
                .clk(clk), .rst_n(rst_n),
                .in_valid(m_iv[R*NP +: NP]), .in_flit(m_ifl[R*NP*FW +: NP*FW]),
                .in_ready(m_ir[R*NP +: NP]),
                .out_valid(m_ov[R*NP +: NP]), .out_flit(m_ofl[R*NP*FW +: NP*FW]),
                .out_ready(m_or[R*NP +: NP])
            );
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk_flit(input int x, input int y, input int pl);
        return {CW'(x), CW'(y), PW'(pl)};
    endfunction

    // 0 local, 1 north, 2 south, 3 east, 4 west
    function automatic int exp_port(input int x, input int y, input int mx, input int my);
        if (x > mx) return 3;
        if (x < mx) return 4;
        if (y > my) return 1;
        if (y < my) return 2;
        return 0;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [FW-1:0] f;
        logic [FW-1:0] f2;
        int ep;
        int prev;
        int w;
        int k;
        int wins [NP];
        string tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(u_ov == '0, "R1", "router outputs during reset", u_ov, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(u_ov == '0, "R1", "router outputs after reset", u_ov, 0);
        chk(m_ov == '0, "R1", "mesh outputs after reset", m_ov, 0);

        // sweep: every input port to every destination coordinate
        for (int i = 0; i < NP; i++) begin
            for (int dx = 0; dx < 4; dx++) begin
                for (int dy = 0; dy < 4; dy++) begin
                    @(negedge clk);
                    f = mk_flit(dx, dy, i*16 + dx*4 + dy);
                    u_iv = '0;
                    u_iv[i] = 1'b1;
                    u_ifl[i*FW +: FW] = f;
                    #1;
                    chk(u_ir == (NP'(1) << i), "R6", "single input accepted", u_ir, NP'(1) << i);
                    @(posedge clk);
                    @(negedge clk);
                    u_iv = '0;
                    ep = exp_port(dx, dy, 1, 1);
                    tag = (dx != 1) ? "R2" : ((dy != 1) ? "R3" : "R4");
                    chk(u_ov == (NP'(1) << ep), tag, "output port", u_ov, NP'(1) << ep);
                    chk(u_ofl[ep*FW +: FW] == f, "R8", "flit after one edge", u_ofl[ep*FW +: FW], f);
                end
            end
        end

        // stall on the east output
        @(negedge clk);
        u_or = 5'b10111;
        f = mk_flit(3, 0, 8'hA5);
        f2 = mk_flit(3, 2, 8'h5A);
        u_iv = 5'b00001;
        u_ifl[0 +: FW] = f;
        #1;
        chk(u_ir[0] == 1'b1, "R5", "empty stalled output accepts", u_ir, 1);
        @(posedge clk);
        @(negedge clk);
        u_ifl[0 +: FW] = f2;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(u_ir[0] == 1'b0, "R5", "full stalled output refuses", u_ir[0], 0);
            chk(u_ov[3] == 1'b1 && u_ofl[3*FW +: FW] == f, "R5", "stalled flit held",
                u_ofl[3*FW +: FW], f);
            @(posedge clk);
            @(negedge clk);
        end
        u_or = '1;
        #1;
        chk(u_ir[0] == 1'b1, "R5", "released output accepts", u_ir[0], 1);
        @(posedge clk);
        @(negedge clk);
        u_iv = '0;
        chk(u_ofl[3*FW +: FW] == f2, "R5", "next flit after release", u_ofl[3*FW +: FW], f2);
        @(posedge clk);
        @(negedge clk);
        chk(u_ov == '0, "R5", "outputs drained", u_ov, 0);

        // five inputs to five distinct outputs
        @(negedge clk);
        u_iv = '1;
        u_ifl[0*FW +: FW] = mk_flit(3, 1, 8'h10);  // east
        u_ifl[1*FW +: FW] = mk_flit(1, 0, 8'h11);  // south
        u_ifl[2*FW +: FW] = mk_flit(1, 3, 8'h12);  // north
        u_ifl[3*FW +: FW] = mk_flit(0, 2, 8'h13);  // west
        u_ifl[4*FW +: FW] = mk_flit(1, 1, 8'h14);  // local
        #1;
        chk(u_ir == '1, "R9", "all distinct inputs accepted", u_ir, 5'h1f);
        @(posedge clk);
        @(negedge clk);
        u_iv = '0;
        chk(u_ov == '1, "R9", "all outputs valid", u_ov, 5'h1f);
        chk(u_ofl[3*FW +: FW] == mk_flit(3, 1, 8'h10), "R9", "east flit", u_ofl[3*FW +: FW], mk_flit(3, 1, 8'h10));
        chk(u_ofl[2*FW +: FW] == mk_flit(1, 0, 8'h11), "R9", "south flit", u_ofl[2*FW +: FW], mk_flit(1, 0, 8'h11));
        chk(u_ofl[1*FW +: FW] == mk_flit(1, 3, 8'h12), "R9", "north flit", u_ofl[1*FW +: FW], mk_flit(1, 3, 8'h12));
        chk(u_ofl[4*FW +: FW] == mk_flit(0, 2, 8'h13), "R9", "west flit", u_ofl[4*FW +: FW], mk_flit(0, 2, 8'h13));
        chk(u_ofl[0*FW +: FW] == mk_flit(1, 1, 8'h14), "R9", "local flit", u_ofl[0*FW +: FW], mk_flit(1, 1, 8'h14));

        // three contenders for the east output
        @(negedge clk);
        for (int i = 0; i < NP; i++) wins[i] = 0;
        u_iv = 5'b10011;
        u_ifl[0*FW +: FW] = mk_flit(3, 0, 0);
        u_ifl[1*FW +: FW] = mk_flit(2, 3, 1);
        u_ifl[4*FW +: FW] = mk_flit(3, 2, 4);
        prev = -1;
        for (int c = 0; c < 6; c++) begin
            #1;
            chk($countones(u_ir) == 1 && (u_ir & 5'b01100) == '0, "R7", "one contender granted",
                u_ir, 0);
            w = 0;
            for (int i = 0; i < NP; i++) if (u_ir[i]) w = i;
            chk(w != prev, "R7", "winner changes", w, prev);
            wins[w]++;
            prev = w;
            @(posedge clk);
            @(negedge clk);
        end
        u_iv = '0;
        chk(wins[0] == 2 && wins[1] == 2 && wins[4] == 2, "R7", "even share over six grants",
            {wins[0][7:0], wins[1][7:0], wins[4][7:0]}, 24'h020202);

        // mesh: every source to every destination
        for (int s = 0; s < NN; s++) begin
            for (int d = 0; d < NN; d++) begin
                @(negedge clk);
                f = mk_flit(d % MS, d / MS, s*NN + d);
                inj_v = '0;
                inj_v[s] = 1'b1;
                inj_f[s*FW +: FW] = f;
                #1;
                chk(m_ir[s*NP] == 1'b1, "R10", "injection accepted", m_ir[s*NP], 1);
                @(posedge clk);
                @(negedge clk);
                inj_v = '0;
                k = 1;
                while (!m_ov[d*NP] && k < 12) begin
                    @(posedge clk);
                    @(negedge clk);
                    k++;
                end
                ep = iabs(s % MS - d % MS) + iabs(s / MS - d / MS) + 1;
                chk(m_ov[d*NP] == 1'b1 && k == ep, "R10", "delivery edge count", k, ep);
                chk(m_ofl[(d*NP)*FW +: FW] == f, "R10", "delivered flit", m_ofl[(d*NP)*FW +: FW], f);
            end
        end

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule